// File: doc/BRIEF.md
# FIFO Threshold Interrupt and DMA Request Unit

This block gathers the status, interrupt and DMA-request logic of a serial controller that sits between two FIFOs: one carries words out to the wire and one carries received words back to software. It does not hold the FIFOs. It watches their fill levels and their push and pop strobes, and it watches a busy indication and a contention pulse from the serial engine. From these it builds a status word, six raw interrupt sources, a software mask, a masked pending view, one combined interrupt line and two watermark-driven DMA requests.

The transmit and receive sides use thresholds in opposite senses. The transmit side asks for service when its FIFO has drained to its threshold or below. The receive side asks for service when its FIFO holds more words than its threshold. A threshold write whose value lies outside the legal range for its side leaves the register unchanged. The four event-type interrupts are sticky. Software clears them by reading a clear register, either one source at a time or all together.

Register access uses a plain strobe interface. Read data follows the address in the same cycle. A read's clearing effect takes hold at the clock edge where the read strobe is sampled.

Top module: `fifo_flag_unit`

## Requirements
- R1: After a synchronous reset, the thresholds, mask, DMA enables, DMA levels and sticky events are all zero. With both levels at 0, the raw word (address 0x8) reads 8'h01, and irq, tx_dma_req and rx_dma_req are low.
- R2: Raw bit 0 (transmit service) is 1 exactly when tx_level <= the transmit threshold (address 0x0). It follows the level with no latching.
- R3: Raw bit 4 (receive service) is 1 exactly when rx_level >= the receive threshold (address 0x1) + 1. It follows the level with no latching.
- R4: A write to address 0x0 takes effect only if the value is below DEPTH. A write to address 0x1 takes effect only if the value is at most DEPTH. A write outside these ranges leaves the register unchanged.
- R5: Raw bits 1, 2, 3 and 5 are sticky. Bit 1 sets on tx_push while tx_level == DEPTH. Bit 3 sets on rx_push while rx_level == DEPTH. Bit 2 sets on rx_pop while rx_level == 0. Bit 5 sets on a contention pulse. Each bit stays set until it is cleared.
- R6: The mask (address 0x2, bits 5:0, 1 = enabled) uses the same bit order as the raw word. The pending word (address 0x7) equals raw AND mask. irq is the OR of the pending bits.
- R7: Reading address 0x9, 0xB, 0xA or 0xC returns raw bit 1, 2, 3 or 5 respectively in bit 0, and clears only that bit. A new event in the same cycle takes priority, so the bit stays set.
- R8: Reading address 0xD returns irq in bit 0 and clears raw bits 1, 2, 3 and 5 together.
- R9: Writes to addresses 0x6 through 0xD have no effect on any state.
- R10: tx_dma_req is high exactly when the transmit DMA enable (address 0x3, bit 0) is 1 and tx_level <= the transmit DMA level (address 0x4).
- R11: rx_dma_req is high exactly when the receive DMA enable (address 0x3, bit 1) is 1 and rx_level >= the receive DMA level (address 0x5) + 1.
- R12: The status word (address 0x6) has five bits. Bit 0 is engine busy. Bit 1 is transmit not full (tx_level != DEPTH). Bit 2 is transmit empty. Bit 3 is receive not empty. Bit 4 is receive full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_level | input | LVL_W | Transmit FIFO fill count, 0..DEPTH |
| rx_level | input | LVL_W | Receive FIFO fill count, 0..DEPTH |
| engine_busy | input | 1 | Serial engine is mid-transfer |
| tx_push | input | 1 | Write attempt into the transmit FIFO |
| rx_push | input | 1 | Write attempt into the receive FIFO |
| rx_pop | input | 1 | Read attempt from the receive FIFO |
| contention | input | 1 | Pulse: another master drove the bus |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (triggers read-clear) |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr |
| irq | output | 1 | Combined masked interrupt |
| tx_dma_req | output | 1 | Transmit DMA request |
| rx_dma_req | output | 1 | Receive DMA request |

## Verification
The bench targets threshold equality points. A comparator with < instead of <=, or with the +1 left off, shifts the edge at which service is requested by one word. It also writes threshold values exactly at DEPTH and at DEPTH+1. A design with the wrong bound would either store the out-of-range value or reject the legal boundary value. Clearing reads are issued in the same cycle as a new event, and against neighbouring sources. A design that lets the clear win, or that clears the wrong bit, drops interrupts or leaves stale ones behind. Random traffic writes to the read-only and clear addresses and checks that no configuration or sticky state moves.

// File: rtl/fu_pkg.sv
package fu_pkg;

    localparam int IRQ_N  = 6;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 4;

    // raw/mask/pending bit positions
    localparam int B_TXE  = 0;
    localparam int B_TXO  = 1;
    localparam int B_RXU  = 2;
    localparam int B_RXO  = 3;
    localparam int B_RXF  = 4;
    localparam int B_CONT = 5;

    typedef enum logic [ADDR_W-1:0] {
        ADR_TXTH     = 4'h0,
        ADR_RXTH     = 4'h1,
        ADR_MASK     = 4'h2,
        ADR_DMACTL   = 4'h3,
        ADR_TXDL     = 4'h4,
        ADR_RXDL     = 4'h5,
        ADR_STAT     = 4'h6,
        ADR_PEND     = 4'h7,
        ADR_RAW      = 4'h8,
        ADR_CLR_TXO  = 4'h9,
        ADR_CLR_RXO  = 4'hA,
        ADR_CLR_RXU  = 4'hB,
        ADR_CLR_CONT = 4'hC,
        ADR_CLR_ALL  = 4'hD
    } addr_e;

    // sticky event set, one bit per latched source
    typedef struct packed {
        logic cont;
        logic rxo;
        logic rxu;
        logic txo;
    } evt_t;

    // status word, busy in bit 0
    typedef struct packed {
        logic rx_full;
        logic rx_nempty;
        logic tx_empty;
        logic tx_nfull;
        logic busy;
    } stat_t;

    function automatic logic [IRQ_N-1:0] pack_raw(input logic txe, input logic rxf,
                                                  input evt_t ev);
        logic [IRQ_N-1:0] r;
        r         = '0;
        r[B_TXE]  = txe;
        r[B_TXO]  = ev.txo;
        r[B_RXU]  = ev.rxu;
        r[B_RXO]  = ev.rxo;
        r[B_RXF]  = rxf;
        r[B_CONT] = ev.cont;
        return r;
    endfunction

endpackage

// File: rtl/fu_cfg_regs.sv
module fu_cfg_regs
    import fu_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int LVL_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [LVL_W-1:0]  tx_thr,
    output logic [LVL_W-1:0]  rx_thr,
    output logic [IRQ_N-1:0]  irq_mask,
    output logic              tx_dma_en,
    output logic              rx_dma_en,
    output logic [LVL_W-1:0]  tx_dl,
    output logic [LVL_W-1:0]  rx_dl
);
    localparam logic [31:0] DEPTH_U = 32'(DEPTH);

    logic [31:0] wval;
    logic        tx_ok;
    logic        rx_ok;

    assign wval  = {{(32-DATA_W){1'b0}}, wdata};
    assign tx_ok = wval <  DEPTH_U;
    assign rx_ok = wval <= DEPTH_U;

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_thr    <= '0;
            rx_thr    <= '0;
            irq_mask  <= '0;
            tx_dma_en <= 1'b0;
            rx_dma_en <= 1'b0;
            tx_dl     <= '0;
            rx_dl     <= '0;
        end else if (wr_en) begin
            case (addr_e'(wr_addr))
                ADR_TXTH:   if (tx_ok) tx_thr <= wdata[LVL_W-1:0];
                ADR_RXTH:   if (rx_ok) rx_thr <= wdata[LVL_W-1:0];
                ADR_MASK:   irq_mask <= wdata[IRQ_N-1:0];
                ADR_DMACTL: begin
                    tx_dma_en <= wdata[0];
                    rx_dma_en <= wdata[1];
                end
                ADR_TXDL:   tx_dl <= wdata[LVL_W-1:0];
                ADR_RXDL:   rx_dl <= wdata[LVL_W-1:0];
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/fu_sticky.sv
module fu_sticky
    import fu_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  evt_t set_ev,
    input  evt_t clr_ev,
    output evt_t held
);
    localparam int N = $bits(evt_t);

    logic [N-1:0] s_v;
    logic [N-1:0] c_v;
    logic [N-1:0] q_v;

    assign s_v  = set_ev;
    assign c_v  = clr_ev;
    assign held = evt_t'(q_v);

    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)
                q_v[i] <= 1'b0;
            else if (s_v[i])
                q_v[i] <= 1'b1;       // a new event beats a clearing read
            else if (c_v[i])
                q_v[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/fu_watermark.sv
module fu_watermark #(
    parameter int LVL_W = 4
) (
    input  logic [LVL_W-1:0] tx_level,
    input  logic [LVL_W-1:0] rx_level,
    input  logic [LVL_W-1:0] tx_thr,
    input  logic [LVL_W-1:0] rx_thr,
    input  logic [LVL_W-1:0] tx_dl,
    input  logic [LVL_W-1:0] rx_dl,
    input  logic             tx_dma_en,
    input  logic             rx_dma_en,
    output logic             txe_raw,
    output logic             rxf_raw,
    output logic             tx_req,
    output logic             rx_req
);
    // one extra bit so that threshold+1 cannot wrap
    localparam int EXT_W = LVL_W + 1;

    logic [EXT_W-1:0] rx_lvl_x;
    logic [EXT_W-1:0] rx_thr_p1;
    logic [EXT_W-1:0] rx_dl_p1;

    assign rx_lvl_x  = {1'b0, rx_level};
    assign rx_thr_p1 = {1'b0, rx_thr} + EXT_W'(1);
    assign rx_dl_p1  = {1'b0, rx_dl}  + EXT_W'(1);

    assign txe_raw = tx_level <= tx_thr;
    assign rxf_raw = rx_lvl_x >= rx_thr_p1;
    assign tx_req  = tx_dma_en && (tx_level <= tx_dl);
    assign rx_req  = rx_dma_en && (rx_lvl_x >= rx_dl_p1);
endmodule

// File: rtl/fifo_flag_unit.sv
module fifo_flag_unit
    import fu_pkg::*;
#(
    parameter  int DEPTH = 8,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [LVL_W-1:0]  tx_level,
    input  logic [LVL_W-1:0]  rx_level,
    input  logic              engine_busy,
    input  logic              tx_push,
    input  logic              rx_push,
    input  logic              rx_pop,
    input  logic              contention,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq,
    output logic              tx_dma_req,
    output logic              rx_dma_req
);
    localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

    logic [LVL_W-1:0] tx_thr;
    logic [LVL_W-1:0] rx_thr;
    logic [LVL_W-1:0] tx_dl;
    logic [LVL_W-1:0] rx_dl;
    logic [IRQ_N-1:0] irq_mask;
    logic             tx_dma_en;
    logic             rx_dma_en;
    logic             txe_raw;
    logic             rxf_raw;
    evt_t             ev_new;
    evt_t             ev_clr;
    evt_t             ev_held;
    stat_t            stat;
    logic [IRQ_N-1:0] raw_vec;
    logic [IRQ_N-1:0] pend_vec;
    addr_e            a;

    assign a = addr_e'(reg_addr);

    fu_cfg_regs #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_cfg (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (reg_wr),
        .wr_addr  (reg_addr),
        .wdata    (reg_wdata),
        .tx_thr   (tx_thr),
        .rx_thr   (rx_thr),
        .irq_mask (irq_mask),
        .tx_dma_en(tx_dma_en),
        .rx_dma_en(rx_dma_en),
        .tx_dl    (tx_dl),
        .rx_dl    (rx_dl)
    );

    fu_watermark #(.LVL_W(LVL_W)) u_wm (
        .tx_level (tx_level),
        .rx_level (rx_level),
        .tx_thr   (tx_thr),
        .rx_thr   (rx_thr),
        .tx_dl    (tx_dl),
        .rx_dl    (rx_dl),
        .tx_dma_en(tx_dma_en),
        .rx_dma_en(rx_dma_en),
        .txe_raw  (txe_raw),
        .rxf_raw  (rxf_raw),
        .tx_req   (tx_dma_req),
        .rx_req   (rx_dma_req)
    );

    // event detection: push into a full FIFO, pop from an empty one
    always_comb begin
        ev_new.txo  = tx_push && (tx_level == FULL_LVL);
        ev_new.rxo  = rx_push && (rx_level == FULL_LVL);
        ev_new.rxu  = rx_pop  && (rx_level == '0);
        ev_new.cont = contention;
    end

    // read-to-clear decode
    always_comb begin
        ev_clr = '0;
        if (reg_rd) begin
            unique case (a)
                ADR_CLR_TXO:  ev_clr.txo  = 1'b1;
                ADR_CLR_RXO:  ev_clr.rxo  = 1'b1;
                ADR_CLR_RXU:  ev_clr.rxu  = 1'b1;
                ADR_CLR_CONT: ev_clr.cont = 1'b1;
                ADR_CLR_ALL:  ev_clr      = '1;
                default: ;
            endcase
        end
    end

    fu_sticky u_sticky (
        .clk   (clk),
        .rst   (rst),
        .set_ev(ev_new),
        .clr_ev(ev_clr),
        .held  (ev_held)
    );

    assign raw_vec  = pack_raw(txe_raw, rxf_raw, ev_held);
    assign pend_vec = raw_vec & irq_mask;
    assign irq      = |pend_vec;

    always_comb begin
        stat.busy      = engine_busy;
        stat.tx_nfull  = tx_level != FULL_LVL;
        stat.tx_empty  = tx_level == '0;
        stat.rx_nempty = rx_level != '0;
        stat.rx_full   = rx_level == FULL_LVL;
    end

    always_comb begin
        reg_rdata = '0;
        unique case (a)
            ADR_TXTH:     reg_rdata = DATA_W'(tx_thr);
            ADR_RXTH:     reg_rdata = DATA_W'(rx_thr);
            ADR_MASK:     reg_rdata = DATA_W'(irq_mask);
            ADR_DMACTL:   reg_rdata = DATA_W'({rx_dma_en, tx_dma_en});
            ADR_TXDL:     reg_rdata = DATA_W'(tx_dl);
            ADR_RXDL:     reg_rdata = DATA_W'(rx_dl);
            ADR_STAT:     reg_rdata = DATA_W'(stat);
            ADR_PEND:     reg_rdata = DATA_W'(pend_vec);
            ADR_RAW:      reg_rdata = DATA_W'(raw_vec);
            ADR_CLR_TXO:  reg_rdata = DATA_W'(ev_held.txo);
            ADR_CLR_RXO:  reg_rdata = DATA_W'(ev_held.rxo);
            ADR_CLR_RXU:  reg_rdata = DATA_W'(ev_held.rxu);
            ADR_CLR_CONT: reg_rdata = DATA_W'(ev_held.cont);
            ADR_CLR_ALL:  reg_rdata = DATA_W'(irq);
            default:      reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/fu_checker.sv
module fu_checker
    import fu_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int LVL_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic [LVL_W-1:0]  tx_level,
    input logic [LVL_W-1:0]  rx_level,
    input logic              tx_push,
    input logic              rx_push,
    input logic              rx_pop,
    input logic              contention,
    input logic              reg_rd,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [LVL_W-1:0]  tx_thr,
    input logic [LVL_W-1:0]  rx_thr,
    input logic [IRQ_N-1:0]  raw_vec,
    input logic [IRQ_N-1:0]  irq_mask,
    input logic              irq,
    input logic              tx_dma_req,
    input logic [LVL_W-1:0]  tx_dl
);
    localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

    logic clr_any;
    assign clr_any = reg_rd && (reg_addr >= ADR_CLR_TXO) && (reg_addr <= ADR_CLR_ALL);

    assert_tx_thr_range_R4: assert property (@(posedge clk) disable iff (rst)
        32'(tx_thr) < 32'(DEPTH));

    assert_rx_thr_range_R4: assert property (@(posedge clk) disable iff (rst)
        32'(rx_thr) <= 32'(DEPTH));

    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (rst)
        (rx_push && rx_level == FULL_LVL) |=> raw_vec[B_RXO]);

    assert_underflow_R5: assert property (@(posedge clk) disable iff (rst)
        (rx_pop && rx_level == '0) |=> raw_vec[B_RXU]);

    assert_sticky_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (raw_vec[B_CONT] && !clr_any) |=> raw_vec[B_CONT]);

    assert_clear_txo_R7: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && reg_addr == ADR_CLR_TXO && !(tx_push && tx_level == FULL_LVL))
        |=> !raw_vec[B_TXO]);

    assert_clear_all_R8: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && reg_addr == ADR_CLR_ALL && !contention) |=> !raw_vec[B_CONT]);

    assert_irq_mask_R6: assert property (@(posedge clk) disable iff (rst)
        irq |-> ((raw_vec & irq_mask) != '0));

    assert_tx_dma_R10: assert property (@(posedge clk) disable iff (rst)
        tx_dma_req |-> (tx_level <= tx_dl));
endmodule

bind fifo_flag_unit fu_checker #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .tx_level  (tx_level),
    .rx_level  (rx_level),
    .tx_push   (tx_push),
    .rx_push   (rx_push),
    .rx_pop    (rx_pop),
    .contention(contention),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .tx_thr    (tx_thr),
    .rx_thr    (rx_thr),
    .raw_vec   (raw_vec),
    .irq_mask  (irq_mask),
    .irq       (irq),
    .tx_dma_req(tx_dma_req),
    .tx_dl     (tx_dl)
);

// File: tb/fifo_flag_unit_bench.sv
module fifo_flag_unit_bench;
    localparam int DEPTH = 8;
    localparam int LVL_W = 4;

    logic       clk = 1'b0;
    logic       rst;
    logic [3:0] tx_level, rx_level;
    logic       engine_busy, tx_push, rx_push, rx_pop, contention;
    logic       reg_wr, reg_rd;
    logic [3:0] reg_addr;
    logic [7:0] reg_wdata;
    logic [7:0] reg_rdata;
    logic       irq, tx_dma_req, rx_dma_req;

    always #5 clk = ~clk;

    fifo_flag_unit #(.DEPTH(DEPTH)) u_fifo_flag_unit (
        .clk(clk), .rst(rst), .tx_level(tx_level), .rx_level(rx_level),
        .engine_busy(engine_busy), .tx_push(tx_push), .rx_push(rx_push),
        .rx_pop(rx_pop), .contention(contention), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq), .tx_dma_req(tx_dma_req),
        .rx_dma_req(rx_dma_req)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // reference state
    logic [3:0] m_txth, m_rxth, m_txdl, m_rxdl;
    logic [5:0] m_mask;
    logic       m_txen, m_rxen;
    logic       s_txo, s_rxu, s_rxo, s_cont;

    task automatic check(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    function automatic logic [5:0] exp_raw();
        logic [5:0] r;
        r[0] = tx_level <= m_txth;
        r[1] = s_txo;
        r[2] = s_rxu;
        r[3] = s_rxo;
        r[4] = {1'b0, rx_level} >= {1'b0, m_rxth} + 5'd1;
        r[5] = s_cont;
        return r;
    endfunction

    function automatic logic exp_irq();
        return |(exp_raw() & m_mask);
    endfunction

    function automatic logic [7:0] exp_rdata(input logic [3:0] a);
        case (a)
            4'h0: return {4'b0, m_txth};
            4'h1: return {4'b0, m_rxth};
            4'h2: return {2'b0, m_mask};
            4'h3: return {6'b0, m_rxen, m_txen};
            4'h4: return {4'b0, m_txdl};
            4'h5: return {4'b0, m_rxdl};
            4'h6: return {3'b0, rx_level == 4'(DEPTH), rx_level != 0, tx_level == 0,
                          tx_level != 4'(DEPTH), engine_busy};
            4'h7: return {2'b0, exp_raw() & m_mask};
            4'h8: return {2'b0, exp_raw()};
            4'h9: return {7'b0, s_txo};
            4'hA: return {7'b0, s_rxo};
            4'hB: return {7'b0, s_rxu};
            4'hC: return {7'b0, s_cont};
            4'hD: return {7'b0, exp_irq()};
            default: return 8'h00;
        endcase
    endfunction

    function automatic string req_of(input logic [3:0] a);
        case (a)
            4'h0, 4'h1: return "R4";
            4'h2, 4'h7: return "R6";
            4'h3, 4'h4: return "R10";
            4'h5:       return "R11";
            4'h6:       return "R12";
            4'h8:       return "R5";
            4'hD:       return "R8";
            4'h9, 4'hA, 4'hB, 4'hC: return "R7";
            default:    return "R9";
        endcase
    endfunction

    // one cycle: drive, check combinational outputs, update reference
    task automatic step(input logic [3:0] tl, input logic [3:0] rl, input logic bsy,
                        input logic tp, input logic rp, input logic rpo, input logic ct,
                        input logic wr, input logic rd, input logic [3:0] a,
                        input logic [7:0] wd);
        logic n_txo, n_rxu, n_rxo, n_cont;
        tx_level = tl; rx_level = rl; engine_busy = bsy;
        tx_push = tp; rx_push = rp; rx_pop = rpo; contention = ct;
        reg_wr = wr; reg_rd = rd; reg_addr = a; reg_wdata = wd;
        #1;
        check("R6",  int'(irq),        int'(exp_irq()));
        check("R10", int'(tx_dma_req), int'(m_txen && tx_level <= m_txdl));
        check("R11", int'(rx_dma_req), int'(m_rxen && {1'b0, rx_level} >= {1'b0, m_rxdl} + 5'd1));
        check(req_of(a), int'(reg_rdata), int'(exp_rdata(a)));
        // next sticky state: event beats clear
        n_txo  = (tp && tl == 4'(DEPTH)) || (s_txo  && !(rd && (a == 4'h9 || a == 4'hD)));
        n_rxo  = (rp && rl == 4'(DEPTH)) || (s_rxo  && !(rd && (a == 4'hA || a == 4'hD)));
        n_rxu  = (rpo && rl == 0)        || (s_rxu  && !(rd && (a == 4'hB || a == 4'hD)));
        n_cont = ct                      || (s_cont && !(rd && (a == 4'hC || a == 4'hD)));
        s_txo = n_txo; s_rxo = n_rxo; s_rxu = n_rxu; s_cont = n_cont;
        if (wr) begin
            case (a)
                4'h0: if (wd < DEPTH)  m_txth = wd[3:0];
                4'h1: if (wd <= DEPTH) m_rxth = wd[3:0];
                4'h2: m_mask = wd[5:0];
                4'h3: begin m_txen = wd[0]; m_rxen = wd[1]; end
                4'h4: m_txdl = wd[3:0];
                4'h5: m_rxdl = wd[3:0];
                default: ;
            endcase
        end
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr_reg(input logic [3:0] a, input logic [7:0] d, input logic [3:0] tl,
                          input logic [3:0] rl);
        step(tl, rl, 0, 0, 0, 0, 0, 1, 0, a, d);
    endtask

    task automatic peek(input logic [3:0] a, input logic [3:0] tl, input logic [3:0] rl);
        tx_level = tl; rx_level = rl; reg_addr = a; reg_rd = 0; reg_wr = 0;
        tx_push = 0; rx_push = 0; rx_pop = 0; contention = 0;
        #1;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: got hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'h5eed));
        {m_txth, m_rxth, m_txdl, m_rxdl} = '0;
        m_mask = '0; m_txen = 0; m_rxen = 0;
        {s_txo, s_rxu, s_rxo, s_cont} = '0;
        rst = 1;
        tx_level = 0; rx_level = 0; engine_busy = 0; tx_push = 0; rx_push = 0;
        rx_pop = 0; contention = 0; reg_wr = 0; reg_rd = 0; reg_addr = 0; reg_wdata = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;

        // R1: reset state
        peek(4'h8, 0, 0);
        check("R1", int'(reg_rdata), 8'h01);
        check("R1", int'(irq), 0);
        check("R1", int'(tx_dma_req | rx_dma_req), 0);

        // R2: transmit service at threshold edge
        wr_reg(4'h2, 8'h01, 0, 0);
        wr_reg(4'h0, 8'd3, 5, 0);
        peek(4'h8, 3, 0);
        check("R2", int'(irq), 1);
        peek(4'h8, 4, 0);
        check("R2", int'(irq), 0);

        // R4: bounds on threshold writes
        wr_reg(4'h0, 8'd8, 4, 0);
        peek(4'h0, 4, 0);
        check("R4", int'(reg_rdata), 3);
        wr_reg(4'h1, 8'd8, 4, 0);
        peek(4'h1, 4, 0);
        check("R4", int'(reg_rdata), 8);
        wr_reg(4'h1, 8'd9, 4, 0);
        peek(4'h1, 4, 0);
        check("R4", int'(reg_rdata), 8);

        // R3: receive service needs threshold+1 words
        wr_reg(4'h1, 8'd2, 4, 0);
        wr_reg(4'h2, 8'h10, 4, 0);
        peek(4'h8, 4, 2);
        check("R3", int'(irq), 0);
        peek(4'h8, 4, 3);
        check("R3", int'(irq), 1);

        // R5/R7: overflow set, clear collides with new event, then clear alone
        wr_reg(4'h2, 8'h02, 4, 0);
        step(8, 0, 0, 1, 0, 0, 0, 0, 0, 4'h8, 0);
        step(8, 0, 0, 1, 0, 0, 0, 0, 1, 4'h9, 0);
        peek(4'h9, 8, 0);
        check("R7", int'(reg_rdata), 1);
        step(8, 0, 0, 0, 0, 0, 0, 0, 1, 4'h9, 0);
        peek(4'h9, 8, 0);
        check("R7", int'(reg_rdata), 0);

        // R9: writes to read-only and clear addresses do nothing
        step(0, 0, 0, 0, 0, 1, 1, 0, 0, 4'h8, 0);
        for (int a = 6; a <= 13; a++) wr_reg(4'(a), 8'hFF, 0, 0);
        peek(4'h8, 0, 0);
        check("R9", int'(reg_rdata), 8'h25);
        peek(4'h2, 0, 0);
        check("R9", int'(reg_rdata), 8'h02);
        // R8: combined clear
        step(0, 0, 0, 0, 0, 0, 0, 0, 1, 4'hD, 0);
        peek(4'h8, 0, 0);
        check("R8", int'(reg_rdata), 8'h01);

        // random traffic
        for (int i = 0; i < 4000; i++) begin
            logic [7:0] wd;
            logic [3:0] a;
            int op;
            wd = ($urandom % 4 == 0) ? 8'($urandom % 64) : 8'($urandom % 10);
            a  = 4'($urandom % 15);
            op = $urandom % 4;
            step(4'($urandom_range(0, DEPTH)), 4'($urandom_range(0, DEPTH)),
                 1'($urandom), ($urandom % 5 == 0), ($urandom % 5 == 0),
                 ($urandom % 5 == 0), ($urandom % 9 == 0),
                 op == 0, op == 1, a, wd);
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule